// File: doc/BRIEF.md
# Dynamic Row-Pair Hit Formatter

This block sits after the end of a pixel column pair and turns a stream of triggered hits into compact 24-bit words. Hits arrive one per cycle, sorted by column and then by row. Each hit carries a 7-bit column, a 9-bit row and a protected 4-bit time-over-threshold (ToT) value. The protection is a 7-bit single-error-correcting Hamming codeword. The block first repairs the codeword. It then pairs the hit with the hit in the next row of the same column, when that hit is present. A pair can begin on any row, even or odd, so the pairing follows the hits that actually occur. A hit without a partner is sent alone, with a reserved code marking the empty second slot.

A single-cycle end-of-event beat closes an event. Any hit still waiting for a partner leaves first, and a marker word follows it. The output uses a valid/ready handshake towards a FIFO that feeds a later 8b/10b serialiser. When the FIFO is not ready, the block holds its input. A saturating counter reports how many accepted hits needed a bit correction. The array the block serves is 80 columns by 336 rows.

Top module: `hit_pair_formatter`

## Requirements
- R1: An output word is laid out as column in bits [23:17], row of the first hit in [16:8], ToT of the first hit in [7:4] and ToT of the second hit in [3:0]. Hits carry ToT values 0 to 14. Hit B is merged into the word of the held hit A when B has the same column and row(A)+1.
- R2: Pairing is dynamic. A pair may start on an even or an odd row. Once a word has consumed a pair, the next hit always opens a new word. For example, rows r, r+1 and r+2 give one pair and then a held single.
- R3: A held hit is emitted alone, with 15 in bits [3:0], when the next hit is in another column or is not at row+1.
- R4: The ToT codeword bit i holds Hamming position i+1. Parity sits at positions 1, 2 and 4. Data bits d0, d1, d2 and d3 sit at positions 3, 5, 6 and 7. Any single flipped bit is corrected before formatting.
- R5: An end-of-event beat (in_eoe=1) ignores the column, row and codeword inputs. Any held hit is emitted first, as a single. A marker word with out_eoe=1 and out_data=0 then follows.
- R6: err_count increments by one for each accepted hit whose codeword has a nonzero syndrome. It saturates at all ones.
- R7: While out_valid=1 and out_ready=0, out_data and out_eoe stay stable. No word is lost or duplicated under backpressure.
- R8: After reset, out_valid=0, no hit is held, in_ready=1 and err_count=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The formatter takes the beat at this edge |
| in_eoe | input | 1 | The beat is an end-of-event marker |
| in_col | input | 7 | Column address of the hit |
| in_row | input | 9 | Row address of the hit |
| in_tot_cw | input | 7 | Hamming codeword of the ToT |
| out_valid | output | 1 | An output word is presented |
| out_ready | input | 1 | The downstream FIFO accepts the word |
| out_data | output | 24 | Formatted word |
| out_eoe | output | 1 | The word is an end-of-event marker |
| err_count | output | ERR_W (16) | Saturating count of corrected codewords |

## Verification
An end-of-event beat can arrive while a hit is still held. In that cycle the block must both flush the held hit and defer the marker. The bench provokes this by closing events right after unpaired hits, while out_ready is pulled low at random. The scoreboard then checks that the flushed single leaves strictly before the marker, and that each leaves exactly once. Error correction and merging also meet in one cycle when the second partner carries a flipped bit. In that case the corrected ToT must appear in bits [3:0], and the counter must still step by one.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int COL_W  = 7;
  localparam int ROW_W  = 9;
  localparam int TOT_W  = 4;
  localparam int CW_W   = 7;
  localparam int WORD_W = COL_W + ROW_W + 2 * TOT_W;
  localparam logic [TOT_W-1:0] NO_PARTNER = '1;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [TOT_W-1:0] tot;
  } hit_t;

  function automatic logic [WORD_W-1:0] pack_word(input hit_t h, input logic [TOT_W-1:0] tot2);
    return {h.col, h.row, h.tot, tot2};
  endfunction

  // Syndrome equals the 1-based position of a single flipped bit
  function automatic logic [2:0] syndrome(input logic [CW_W-1:0] cw);
    logic [2:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++)
      if (cw[p-1]) s ^= 3'(p);
    return s;
  endfunction

  function automatic logic [TOT_W-1:0] extract_data(input logic [CW_W-1:0] cw);
    return {cw[6], cw[5], cw[4], cw[2]};
  endfunction

  function automatic logic row_follows(input hit_t held, input logic [COL_W-1:0] col,
                                       input logic [ROW_W-1:0] row);
    return (col == held.col) && (row == held.row + ROW_W'(1));
  endfunction
endpackage

// File: rtl/hpf_hamming_dec.sv
module hpf_hamming_dec
  import hpf_pkg::*;
(
  input  logic [CW_W-1:0]  cw,
  output logic [TOT_W-1:0] data,
  output logic             corrected
);
  logic [2:0]      syn;
  logic [CW_W-1:0] fixed;

  always_comb begin
    syn   = syndrome(cw);
    fixed = cw;
    for (int p = 1; p <= CW_W; p++)
      if (syn == 3'(p)) fixed[p-1] = ~cw[p-1];
    data      = extract_data(fixed);
    corrected = (syn != 3'd0);
  end
endmodule

// File: rtl/hpf_err_counter.sv
module hpf_err_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (inc && count != TOP) count <= count + W'(1);
  end
endmodule

// File: rtl/hpf_pair_merger.sv
module hpf_pair_merger
  import hpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_eoe,
  input  hit_t              in_hit,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_eoe,
  output logic              pend_valid,
  output logic              merge_evt,
  output logic              flush_evt,
  output logic              hit_acc
);
  hit_t pend_q;
  logic slot, accept, adjacent, break_evt, mark_evt;

  assign slot      = !out_valid || out_ready;
  assign in_ready  = slot && !(in_eoe && pend_valid);
  assign accept    = in_valid && in_ready;
  assign hit_acc   = accept && !in_eoe;
  assign mark_evt  = accept && in_eoe;
  assign adjacent  = pend_valid && row_follows(pend_q, in_hit.col, in_hit.row);
  assign merge_evt = hit_acc && adjacent;
  assign break_evt = hit_acc && pend_valid && !adjacent;
  assign flush_evt = in_valid && in_eoe && pend_valid && slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eoe   <= 1'b0;
    end else if (slot) begin
      out_valid <= merge_evt || break_evt || mark_evt || flush_evt;
      out_eoe   <= mark_evt;
      if (merge_evt)                   out_data <= pack_word(pend_q, in_hit.tot);
      else if (break_evt || flush_evt) out_data <= pack_word(pend_q, NO_PARTNER);
      else                             out_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_q     <= '0;
    end else if (merge_evt || flush_evt) begin
      pend_valid <= 1'b0;
    end else if (hit_acc) begin
      pend_valid <= 1'b1;
      pend_q     <= in_hit;
    end
  end
endmodule

// File: rtl/hit_pair_formatter.sv
module hit_pair_formatter
  import hpf_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_eoe,
  input  logic [COL_W-1:0]  in_col,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [CW_W-1:0]   in_tot_cw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_eoe,
  output logic [ERR_W-1:0]  err_count
);
  logic [TOT_W-1:0] tot_fixed;
  logic             corr_bit, corr_evt, pend_valid, merge_evt, flush_evt, hit_acc;
  hit_t             hit;

  hpf_hamming_dec u_dec (.cw(in_tot_cw), .data(tot_fixed), .corrected(corr_bit));

  assign hit = '{col: in_col, row: in_row, tot: tot_fixed};

  hpf_pair_merger u_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eoe(in_eoe), .in_hit(hit),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_eoe(out_eoe), .pend_valid(pend_valid),
    .merge_evt(merge_evt), .flush_evt(flush_evt), .hit_acc(hit_acc)
  );

  assign corr_evt = hit_acc && corr_bit;

  hpf_err_counter #(.W(ERR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(corr_evt), .count(err_count)
  );
endmodule

// File: rtl/hpf_checker.sv
module hpf_checker #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eoe,
  input logic             out_valid,
  input logic             out_ready,
  input logic [23:0]      out_data,
  input logic             out_eoe,
  input logic [ERR_W-1:0] err_count,
  input logic             pend_valid,
  input logic             merge_evt,
  input logic             flush_evt,
  input logic             corr_evt
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eoe)); // R7
  AST_MARKER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eoe |-> out_data == 24'd0); // R5
  AST_EOE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_eoe && pend_valid |-> !in_ready); // R5
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> out_valid && !out_eoe && out_data[3:0] == 4'hF); // R3
  AST_MERGE_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    merge_evt |=> out_valid && !out_eoe && out_data[3:0] != 4'hF); // R1
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    corr_evt && err_count != '1 |=> err_count == $past(err_count) + 1'b1); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_evt |=> $stable(err_count)); // R6
endmodule

bind hit_pair_formatter hpf_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eoe(out_eoe),
  .err_count(err_count), .pend_valid(pend_valid), .merge_evt(merge_evt),
  .flush_evt(flush_evt), .corr_evt(corr_evt)
);

// File: tb/tb_hit_pair_formatter.sv
module tb_hit_pair_formatter;
  localparam int EW = 4;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_eoe = 0, out_ready = 1;
  logic [6:0] in_col = 0;
  logic [8:0] in_row = 0;
  logic [6:0] in_tot_cw = 0;
  logic in_ready, out_valid, out_eoe;
  logic [23:0] out_data;
  logic [EW-1:0] err_count;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit stall_mode = 0;
  logic [23:0] q_d[$];
  logic        q_e[$];
  string       q_r[$];
  bit   m_pv = 0;
  logic [6:0] m_col;
  logic [8:0] m_row;
  logic [3:0] m_tot;
  int   m_err = 0;

  always #4 clk = ~clk;

  hit_pair_formatter #(.ERR_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
    .in_col(in_col), .in_row(in_row), .in_tot_cw(in_tot_cw), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_eoe(out_eoe), .err_count(err_count)
  );

  // R4 encoder: positions 3,5,6,7 carry d0..d3; parity at 1,2,4
  function automatic logic [6:0] enc(input logic [3:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p4, d[0], p2, p1};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [23:0] d, input logic e, input string r);
    q_d.push_back(d); q_e.push_back(e); q_r.push_back(r);
  endtask

  task automatic drive(input logic eoe, input logic [6:0] c, input logic [8:0] r,
                       input logic [6:0] cw);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1; in_eoe = eoe; in_col = c; in_row = r; in_tot_cw = cw;
      #2 done = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_eoe = 0;
  endtask

  // flip in 0..6 flips that codeword bit, 7 sends it clean
  task automatic send_hit(input logic [6:0] c, input logic [8:0] r, input logic [3:0] t,
                          input int flip, input string req);
    logic [6:0] cw = enc(t);
    if (flip < 7) begin
      cw[flip] = ~cw[flip];
      if (m_err < (1 << EW) - 1) m_err++;
    end
    if (m_pv && c == m_col && r == m_row + 9'd1) begin
      expect_word({m_col, m_row, m_tot, t}, 0, req);
      m_pv = 0;
    end else begin
      if (m_pv) expect_word({m_col, m_row, m_tot, 4'hF}, 0, "R3");
      m_pv = 1; m_col = c; m_row = r; m_tot = t;
    end
    drive(0, c, r, cw);
  endtask

  task automatic send_eoe();
    if (m_pv) expect_word({m_col, m_row, m_tot, 4'hF}, 0, "R5");
    m_pv = 0;
    expect_word(24'd0, 1, "R5");
    drive(1, 7'h55, 9'h1AA, 7'h7F);   // field values must be ignored
  endtask

  task automatic drain();
    int guard = 0;
    while ((q_d.size() != 0 || out_valid) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        if (q_d.size() == 0) check("R7 unexpected word", {7'd0, out_eoe, out_data}, 32'hDEAD);
        else begin
          check(q_r[0], {7'd0, out_eoe, out_data}, {7'd0, q_e[0], q_d[0]});
          void'(q_d.pop_front()); void'(q_e.pop_front()); void'(q_r.pop_front());
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 out_valid", out_valid, 0);
    check("R8 in_ready", in_ready, 1);
    check("R8 err_count", err_count, 0);
    rst_n = 1;
    // R1 pair on even row, R2 pair on odd row, R4 corrected partner
    send_hit(3, 10, 4'd5, 7, "R1");
    send_hit(3, 11, 4'd9, 7, "R1");
    send_hit(3, 21, 4'd2, 7, "R2");
    send_hit(3, 22, 4'd14, 4, "R4");
    // R2 three rows: pair then held single
    send_hit(4, 40, 4'd1, 7, "R2");
    send_hit(4, 41, 4'd7, 0, "R2");
    send_hit(4, 42, 4'd3, 7, "R2");
    // R3 gap then column change
    send_hit(5, 1, 4'd6, 7, "R3");
    send_hit(5, 3, 4'd8, 6, "R3");
    send_hit(6, 4, 4'd0, 7, "R3");
    send_eoe();                       // R5 flush then marker
    send_eoe();                       // R5 marker only
    send_hit(79, 334, 4'd13, 2, "R1");
    send_hit(79, 335, 4'd12, 7, "R1");
    send_eoe();
    drain();
    check("R6 err_count directed", err_count, 32'(m_err));
    // R7 random backpressure with corrections driving R6 saturation
    stall_mode = 1;
    begin
      logic [6:0] c = 0;
      logic [8:0] r = 0;
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 6 == 0) begin c = 7'(($urandom % 80)); r = 9'($urandom % 300); end
        else r = r + 9'(1 + ($urandom % 2));
        if (r > 335) r = 0;
        send_hit(c, r, 4'($urandom % 15), int'($urandom % 10), "R7");
        if ($urandom % 9 == 0) send_eoe();
      end
      send_eoe();
    end
    stall_mode = 0;
    drain();
    check("R6 err_count saturated", err_count, 32'(m_err));
    check("R7 queue empty", q_d.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule